// File: doc/BRIEF.md
# Masked-LFSR Noise Source for a Three-Voice Tone Generator

This block makes the single noise bit that a three-voice programmable sound generator mixes into its voices. A tick input paces it. On each tick a period counter advances against a programmed noise period. Each time that counter expires, a small prescaler advances. A 17-bit linear feedback shift register (LFSR) supplies the randomness.

In compatibility mode the LFSR steps whenever the prescaler wraps, and the noise bit is LFSR bit 0. In expanded mode a second counter, the value counter, runs on every period expiry against a limit. That limit is the LFSR low byte, first ANDed with one mask byte and then ORed with another. When the value counter reaches the limit, three things happen: it restarts, an output latch flips, and the LFSR steps once. The latch is then the noise bit. This lets software shape the noise into anything from white noise to a plain square wave.

A parameter picks the device variant. The expanded-capable variant honours the expanded-mode flag, uses the bit0/bit2 feedback tap and seeds the LFSR with all ones. The standard variant ignores the flag, uses the bit0/bit3 tap and seeds with 1.

Top module: `psg_noise_gen`

## Requirements
- R1: A synchronous active-high reset loads the LFSR with 0x1FFFF on the expanded-capable variant and with 0x00001 on the standard variant. It also clears the period counter, the prescaler, the value counter and the output latch. Directly after reset, noise_o is therefore 1 in compatibility mode and 0 in expanded mode.
- R2: The effective noise period is period_i[4:0] in compatibility mode and the full period_i[7:0] in expanded mode. The period counter expires on the tick on which its incremented count is greater than or equal to the effective period.
- R3: An effective noise period of 0 behaves exactly like a period of 1, so every tick is an expiry.
- R4: On each expiry the prescaler increments modulo 4 when divide_i is 1 and modulo 2 when divide_i is 0.
- R5: In compatibility mode the LFSR steps only on an expiry whose prescaler increment lands on 0, and noise_o equals LFSR bit 0.
- R6: An LFSR step shifts right by one and puts the feedback into bit 16. The feedback is bit0 XOR bit2 on the expanded-capable variant and bit0 XOR bit3 on the standard variant. The standard variant treats expanded_i as 0.
- R7: In expanded mode, every expiry increments the value counter. If the incremented value is greater than or equal to (LFSR[7:0] AND and-mask) OR or-mask, the counter clears, the output latch toggles and the LFSR steps once. Otherwise the counter keeps the incremented value.
- R8: In expanded mode noise_o equals the output latch. The latch never changes in compatibility mode.
- R9: While tick_i is 0, no counter, prescaler, LFSR or latch state changes.
- R10: The and-mask and or-mask are registers that reset to 0xFF and 0x00. They load and_mask_i and or_mask_i on a clock with mask_we_i high and take effect from the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Advance enable for the noise state |
| expanded_i | input | 1 | 1 selects expanded mode (expanded-capable variant only) |
| divide_i | input | 1 | 1 widens the prescaler to two bits |
| period_i | input | 8 | Noise period |
| mask_we_i | input | 1 | Load strobe for the two mask registers |
| and_mask_i | input | 8 | AND mask applied to the LFSR low byte |
| or_mask_i | input | 8 | OR mask applied after the AND |
| noise_o | output | 1 | Noise bit |

## Verification
The hardest situation to reach from the ports is a chain of expanded-mode latch toggles at a known limit. The limit follows the LFSR low byte, which moves only when the latch itself toggles. With the reset masks, the first limit is 255, so a toggle is rare.

The stimulus uses mask loads to force the limit. An AND mask of 0 with an OR mask of 0 gives limit 0, which toggles on every expiry. A small AND mask with a nonzero OR mask gives short, varying limits. A long run with the default masks covers the large-limit case.

Each of these runs is repeated with the two-bit prescaler, with sparse ticks and with an 8-bit period. A behavioural model is compared against the output on every clock for both variants at once.

// File: rtl/psg_noise_pkg.sv
package psg_noise_pkg;

    localparam int LFSR_W = 17;

    typedef logic [LFSR_W-1:0] lfsr_t;

    // Events produced by the period counter for one tick.
    typedef struct packed {
        logic expire;
        logic pre_wrap;
    } period_ev_t;

    typedef enum logic {
        MODE_COMPAT   = 1'b0,
        MODE_EXPANDED = 1'b1
    } noise_mode_e;

    function automatic lfsr_t lfsr_seed(input bit exp_capable);
        return exp_capable ? {LFSR_W{1'b1}} : lfsr_t'(1);
    endfunction

    // Right shift; feedback into the top bit from bit0 and a variant tap.
    function automatic lfsr_t lfsr_advance(input lfsr_t s, input bit short_tap);
        logic fb;
        fb = s[0] ^ (short_tap ? s[2] : s[3]);
        return {fb, s[LFSR_W-1:1]};
    endfunction

endpackage

// File: rtl/psg_noise_period.sv
module psg_noise_period
    import psg_noise_pkg::*;
#(
    parameter int PERIOD_W = 8,
    parameter int COMPAT_W = 5,
    parameter int PRE_W    = 2
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                tick_i,
    input  noise_mode_e         mode_i,
    input  logic                divide_i,
    input  logic [PERIOD_W-1:0] period_i,
    output period_ev_t          ev_o,
    output logic [PRE_W-1:0]    pre_o
);

    localparam int CW = PERIOD_W + 1;

    logic [PERIOD_W-1:0] cnt_q;
    logic [PRE_W-1:0]    pre_q;
    logic [PERIOD_W-1:0] limit;
    logic [CW-1:0]       cnt_inc;
    logic [PRE_W-1:0]    pre_mask;
    logic [PRE_W-1:0]    pre_inc;

    always_comb begin
        if (mode_i == MODE_EXPANDED)
            limit = period_i;
        else
            limit = {{(PERIOD_W-COMPAT_W){1'b0}}, period_i[COMPAT_W-1:0]};
        if (limit == '0)
            limit = PERIOD_W'(1);
    end

    assign cnt_inc   = {1'b0, cnt_q} + CW'(1);
    assign pre_mask  = divide_i ? {PRE_W{1'b1}} : PRE_W'(1);
    assign pre_inc   = (pre_q + PRE_W'(1)) & pre_mask;

    assign ev_o.expire   = tick_i && (cnt_inc >= {1'b0, limit});
    assign ev_o.pre_wrap = ev_o.expire && (pre_inc == '0);
    assign pre_o         = pre_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
            pre_q <= '0;
        end else if (tick_i) begin
            if (ev_o.expire) begin
                cnt_q <= '0;
                pre_q <= pre_inc;
            end else begin
                cnt_q <= cnt_inc[PERIOD_W-1:0];
            end
        end
    end

endmodule

// File: rtl/psg_noise_masks.sv
module psg_noise_masks #(
    parameter int VALUE_W = 8
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               we_i,
    input  logic [VALUE_W-1:0] and_i,
    input  logic [VALUE_W-1:0] or_i,
    output logic [VALUE_W-1:0] and_q,
    output logic [VALUE_W-1:0] or_q
);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            and_q <= {VALUE_W{1'b1}};
            or_q  <= '0;
        end else if (we_i) begin
            and_q <= and_i;
            or_q  <= or_i;
        end
    end

endmodule

// File: rtl/psg_noise_value.sv
module psg_noise_value #(
    parameter int VALUE_W = 8
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               adv_i,
    input  logic [VALUE_W-1:0] lfsr_low_i,
    input  logic [VALUE_W-1:0] and_mask_i,
    input  logic [VALUE_W-1:0] or_mask_i,
    output logic               step_o,
    output logic               latch_o
);

    localparam int NW = VALUE_W + 1;

    logic [VALUE_W-1:0] val_q;
    logic               latch_q;
    logic [VALUE_W-1:0] limit;
    logic [NW-1:0]      val_inc;

    assign limit   = (lfsr_low_i & and_mask_i) | or_mask_i;
    assign val_inc = {1'b0, val_q} + NW'(1);
    assign step_o  = adv_i && (val_inc >= {1'b0, limit});
    assign latch_o = latch_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            val_q   <= '0;
            latch_q <= 1'b0;
        end else if (adv_i) begin
            if (step_o) begin
                val_q   <= '0;
                latch_q <= ~latch_q;
            end else begin
                val_q <= val_inc[VALUE_W-1:0];
            end
        end
    end

endmodule

// File: rtl/psg_noise_lfsr.sv
module psg_noise_lfsr
    import psg_noise_pkg::*;
#(
    parameter bit EXP_CAPABLE = 1'b1
) (
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  step_i,
    output lfsr_t state_o
);

    localparam lfsr_t SEED = lfsr_seed(EXP_CAPABLE);

    lfsr_t state_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)
            state_q <= SEED;
        else if (step_i)
            state_q <= lfsr_advance(state_q, EXP_CAPABLE);
    end

    assign state_o = state_q;

endmodule

// File: rtl/psg_noise_gen.sv
module psg_noise_gen
    import psg_noise_pkg::*;
#(
    parameter bit EXP_CAPABLE = 1'b1,
    parameter int PERIOD_W    = 8,
    parameter int COMPAT_W    = 5,
    parameter int PRE_W       = 2,
    parameter int VALUE_W     = 8
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                tick_i,
    input  logic                expanded_i,
    input  logic                divide_i,
    input  logic [PERIOD_W-1:0] period_i,
    input  logic                mask_we_i,
    input  logic [VALUE_W-1:0]  and_mask_i,
    input  logic [VALUE_W-1:0]  or_mask_i,
    output logic                noise_o
);

    noise_mode_e        mode;
    period_ev_t         ev;
    logic [PRE_W-1:0]   pre_q;
    lfsr_t              lfsr_q;
    logic [VALUE_W-1:0] and_q;
    logic [VALUE_W-1:0] or_q;
    logic               val_step;
    logic               latch_q;
    logic               lfsr_step;

    generate
        if (EXP_CAPABLE) begin : g_exp
            assign mode = expanded_i ? MODE_EXPANDED : MODE_COMPAT;
        end else begin : g_std
            assign mode = MODE_COMPAT;
        end
    endgenerate

    psg_noise_period #(
        .PERIOD_W (PERIOD_W),
        .COMPAT_W (COMPAT_W),
        .PRE_W    (PRE_W)
    ) u_period (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .tick_i   (tick_i),
        .mode_i   (mode),
        .divide_i (divide_i),
        .period_i (period_i),
        .ev_o     (ev),
        .pre_o    (pre_q)
    );

    psg_noise_masks #(
        .VALUE_W (VALUE_W)
    ) u_masks (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .we_i  (mask_we_i),
        .and_i (and_mask_i),
        .or_i  (or_mask_i),
        .and_q (and_q),
        .or_q  (or_q)
    );

    psg_noise_value #(
        .VALUE_W (VALUE_W)
    ) u_value (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .adv_i      (ev.expire && (mode == MODE_EXPANDED)),
        .lfsr_low_i (lfsr_q[VALUE_W-1:0]),
        .and_mask_i (and_q),
        .or_mask_i  (or_q),
        .step_o     (val_step),
        .latch_o    (latch_q)
    );

    assign lfsr_step = (mode == MODE_EXPANDED) ? val_step : ev.pre_wrap;

    psg_noise_lfsr #(
        .EXP_CAPABLE (EXP_CAPABLE)
    ) u_lfsr (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .step_i  (lfsr_step),
        .state_o (lfsr_q)
    );

    assign noise_o = (mode == MODE_EXPANDED) ? latch_q : lfsr_q[0];

endmodule

// File: rtl/psg_noise_chk.sv
module psg_noise_chk
    import psg_noise_pkg::*;
#(
    parameter bit EXP_CAPABLE = 1'b1,
    parameter int PRE_W       = 2
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             tick_i,
    input logic             expanded_i,
    input lfsr_t            lfsr_q,
    input logic             latch_q,
    input logic [PRE_W-1:0] pre_q
);

    logic exp_eff;
    assign exp_eff = EXP_CAPABLE && expanded_i;

    // R1
    reset_seed_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (lfsr_q == lfsr_seed(EXP_CAPABLE)) && !latch_q);

    // R6
    lfsr_nonzero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        lfsr_q != '0);

    // R9
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !tick_i |=> $stable(lfsr_q) && $stable(latch_q) && $stable(pre_q));

    // R8
    compat_latch_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !exp_eff |=> $stable(latch_q));

    // R5
    compat_wrap_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!exp_eff && tick_i) |=> ($stable(lfsr_q) || (pre_q == '0)));

    // R7
    toggle_steps_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (exp_eff && tick_i) |=> ($stable(latch_q) || !$stable(lfsr_q)));

endmodule

bind psg_noise_gen psg_noise_chk #(
    .EXP_CAPABLE (EXP_CAPABLE),
    .PRE_W       (PRE_W)
) chk_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .tick_i     (tick_i),
    .expanded_i (expanded_i),
    .lfsr_q     (lfsr_q),
    .latch_q    (latch_q),
    .pre_q      (pre_q)
);

// File: tb/psg_noise_gen_tb_top.sv
`timescale 1ns/1ps
module psg_noise_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       expanded = 1'b0;
    logic       divide = 1'b0;
    logic [7:0] period = 8'd1;
    logic       mask_we = 1'b0;
    logic [7:0] and_m = 8'h00;
    logic [7:0] or_m = 8'h00;
    logic       noise_cap;
    logic       noise_std;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    psg_noise_gen #(.EXP_CAPABLE(1'b1)) dut_i (
        .clk_i(clk), .rst_i(rst), .tick_i(tick), .expanded_i(expanded),
        .divide_i(divide), .period_i(period), .mask_we_i(mask_we),
        .and_mask_i(and_m), .or_mask_i(or_m), .noise_o(noise_cap));

    psg_noise_gen #(.EXP_CAPABLE(1'b0)) dut_std_i (
        .clk_i(clk), .rst_i(rst), .tick_i(tick), .expanded_i(expanded),
        .divide_i(divide), .period_i(period), .mask_we_i(mask_we),
        .and_mask_i(and_m), .or_mask_i(or_m), .noise_o(noise_std));

    // Behavioural reference: index 0 = expanded-capable, 1 = standard.
    int m_lf[2], m_cnt[2], m_pre[2], m_val[2], m_lat[2], m_and[2], m_or[2];

    function automatic int shift17(int s, int tap);
        int fb;
        fb = (s & 1) ^ ((s >> tap) & 1);
        return (s >> 1) | (fb << 16);
    endfunction

    always @(posedge clk) begin
        for (int k = 0; k < 2; k++) begin
            if (rst) begin
                m_lf[k]  = (k == 0) ? 'h1FFFF : 1;
                m_cnt[k] = 0; m_pre[k] = 0; m_val[k] = 0; m_lat[k] = 0;
                m_and[k] = 'hFF; m_or[k] = 0;
            end else begin
                bit ex;
                int lim;
                ex = (k == 0) && expanded;
                if (tick) begin
                    lim = ex ? int'(period) : int'(period) % 32;
                    if (lim == 0) lim = 1;
                    m_cnt[k]++;
                    if (m_cnt[k] >= lim) begin
                        m_cnt[k] = 0;
                        m_pre[k] = (m_pre[k] + 1) % (divide ? 4 : 2);
                        if (ex) begin
                            m_val[k]++;
                            if (m_val[k] >= (((m_lf[k] % 256) & m_and[k]) | m_or[k])) begin
                                m_val[k] = 0;
                                m_lat[k] = 1 - m_lat[k];
                                m_lf[k] = shift17(m_lf[k], (k == 0) ? 2 : 3);
                            end
                        end else if (m_pre[k] == 0) begin
                            m_lf[k] = shift17(m_lf[k], (k == 0) ? 2 : 3);
                        end
                    end
                end
                if (mask_we) begin
                    m_and[k] = int'(and_m);
                    m_or[k]  = int'(or_m);
                end
            end
        end
    end

    function automatic bit model_noise(int k);
        if (k == 0 && expanded) return m_lat[0][0];
        return m_lf[k][0];
    endfunction

    task automatic check(logic got, logic exp, string req, string what);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, got, exp);
        end
    endtask

    task automatic compare(string req);
        check(noise_cap, model_noise(0), req, "expanded-capable noise");
        check(noise_std, model_noise(1), req, "standard noise");
    endtask

    // Runs n clocks; tick every cycle when gap==0, else on every gap-th cycle.
    task automatic run(int n, int gap, string req);
        for (int i = 0; i < n; i++) begin
            tick = (gap == 0) ? 1'b1 : ((i % gap) == 0);
            @(posedge clk);
            #2;
            compare(req);
        end
    endtask

    task automatic load_masks(logic [7:0] a, logic [7:0] o);
        and_m = a; or_m = o; mask_we = 1'b1; tick = 1'b0;
        @(posedge clk);
        #2;
        mask_we = 1'b0;
        compare("R10");
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        rst = 1'b0;
        // R1: reset state visible at the output
        check(noise_cap, 1'b1, "R1", "reset compat capable");
        check(noise_std, 1'b1, "R1", "reset compat standard");
        expanded = 1'b1;
        #1;
        check(noise_cap, 1'b0, "R1", "reset expanded latch");
        check(noise_std, 1'b1, "R6", "standard ignores expanded flag");
        expanded = 1'b0;
        #1;

        period = 8'd1;  run(300, 0, "R5");
        run(200, 0, "R6");
        period = 8'd0;  run(150, 0, "R3");
        period = 8'h25; run(300, 0, "R2");
        divide = 1'b1; period = 8'd2; run(400, 0, "R4");
        divide = 1'b0; period = 8'd1; run(300, 3, "R9");

        expanded = 1'b1;
        period = 8'd1; run(3000, 0, "R7");
        load_masks(8'h0F, 8'h03);
        run(1500, 0, "R7");
        load_masks(8'h00, 8'h00);
        divide = 1'b1; period = 8'd3; run(300, 0, "R8");
        period = 8'd0; run(100, 0, "R3");
        period = 8'hC8; run(1200, 0, "R2");
        load_masks(8'h07, 8'h10);
        period = 8'd2; run(600, 2, "R9");
        divide = 1'b0;
        expanded = 1'b0; period = 8'd1; run(300, 0, "R8");

        // Mid-run reset returns to the seed and default masks.
        rst = 1'b1;
        @(posedge clk);
        #2;
        rst = 1'b0;
        compare("R1");
        expanded = 1'b1; run(1500, 0, "R10");

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog all actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule